// File: doc/BRIEF.md
# MDIO Management Master with Selectable Clock Divider

This block is a station-management master for Ethernet PHYs. Software sets up one operation in a 16-bit command register: PHY address, register index, a 4-bit clock code, a write flag and a busy flag. A second 16-bit register holds the data. Setting the busy flag starts one Clause 22 frame on the management clock and data pins. When the frame completes, the block clears busy. For a read, it also loads the data register with the 16 bits returned by the PHY.

The management clock is the input clock divided by an even number, and the 4-bit code picks that number. When the top bit of the code is set, the divisor steps linearly from 4 to 18. When it is clear, the code names the input-clock frequency band, and the block applies a divisor that keeps the management clock within limits for that band. The data pin is split into an output, an output enable and an input, so a pad-level tri-state buffer can be placed outside the block.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the command register and data register read 0, the management clock is low and the data output enable is low.
- R2: Command register layout: bits 15:11 hold the PHY address, bits 10:6 the register index, bits 5:2 the clock code, bit 1 the write flag (1 = write, 0 = read) and bit 0 busy. While idle, a write is stored as given and reads back unchanged. A write with bit 0 = 1 starts a frame. Busy is never set any other way.
- R3: While busy is 1, writes to the command register and writes to the data register are ignored.
- R4: With clock code bit 3 = 1, the management clock period is 4 + 2 x code[2:0] input clocks (codes 8..15 give 4, 6, ..., 18).
- R5: With clock code bit 3 = 0, the code sets the period in input clocks: 2 gives 16, 3 gives 26, 0 gives 42, 1 gives 62, 4 gives 102, 5 gives 124. Codes 6 and 7 give 42.
- R6: The management clock is high for exactly half of each period and stays low whenever busy is 0.
- R7: Every frame is 64 bit periods long, sent MSB first: 32 ones, start bits 01, opcode 10 for a read or 01 for a write, the 5-bit PHY address, then the 5-bit register index.
- R8: For a write, the block drives all 64 bit periods. Bits 46-47 are 10, and bits 48-63 are the data register.
- R9: For a read, the output enable is low for bit periods 46-63. The block samples the data input on each rising management clock edge in bit periods 48-63, MSB first.
- R10: While the data pin is driven, the data output changes only on the input clock edge where the management clock falls.
- R11: Busy stays set for exactly 64 management clock periods. It clears on the edge that ends the last period, and on that same edge read data is loaded into the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that the management clock is divided from |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 16 | Value to write into the command register |
| cmd_rdata | output | 16 | Current command register, including busy |
| data_we | input | 1 | Write strobe for the data register |
| data_wdata | input | 16 | Value to write into the data register |
| data_rdata | output | 16 | Current data register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
Each of the 16 clock codes is exercised once, alternating between write and read frames. From these runs the bench measures the period, the high time and the busy length, which separates the band table, the linear table and the fallback codes. The address, register and data values mix all-ones, all-zeros, single-bit and alternating patterns, so a swapped field, a reversed bit order or a wrong opcode shows up in the captured frame. Directed runs cover the output-enable release during reads, commands and data written in the middle of a frame, and a command write that does not start a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int HALF_W = 7;
   localparam int REG_W  = 16;

   // half period for the frequency-band codes (bit 3 clear)
   function automatic logic [HALF_W-1:0] band_half(input logic [3:0] code);
      logic [HALF_W-1:0] h;
      case (code)
         4'd2:    h = 7'd8;
         4'd3:    h = 7'd13;
         4'd0:    h = 7'd21;
         4'd1:    h = 7'd31;
         4'd4:    h = 7'd51;
         4'd5:    h = 7'd62;
         default: h = 7'd21;
      endcase
      return h;
   endfunction

   // half period for the linear codes (bit 3 set): (4 + 2k) / 2
   function automatic logic [HALF_W-1:0] linear_half(input logic [3:0] code);
      return HALF_W'(2) + HALF_W'(code[2:0]);
   endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int HALF_W = mdio_pkg::HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [HALF_W-1:0] half,
   output logic              mdc,
   output logic              rise_tk,
   output logic              fall_tk
);

   logic [HALF_W-1:0] cnt_q;
   logic              mdc_q;
   logic              tick;

   assign tick    = run && (cnt_q == half - HALF_W'(1));
   assign rise_tk = tick && !mdc_q;
   assign fall_tk = tick && mdc_q;
   assign mdc     = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + HALF_W'(1);
      end
   end

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter #(
   parameter int PRE_LEN = 32,
   localparam int FL     = PRE_LEN + 32,
   localparam int CW     = $clog2(FL + 1),
   localparam int TA_IDX = PRE_LEN + 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_read,
   input  logic [FL-1:0] frame_i,
   input  logic          rise_tk,
   input  logic          fall_tk,
   input  logic          mdio_i,
   output logic          mdio_o,
   output logic          mdio_oe,
   output logic          done,
   output logic [15:0]   rd_data
);

   logic          active_q;
   logic          rd_q;
   logic [CW-1:0] bit_q;
   logic [FL-1:0] sh_q;
   logic [15:0]   rx_q;
   logic          last_bit;

   assign last_bit = (bit_q == CW'(FL - 1));
   assign done     = active_q && fall_tk && last_bit;
   assign mdio_o   = active_q && sh_q[FL-1];
   assign mdio_oe  = active_q && !(rd_q && (bit_q >= CW'(TA_IDX)));
   assign rd_data  = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rd_q     <= 1'b0;
         bit_q    <= '0;
         sh_q     <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         rd_q     <= is_read;
         bit_q    <= '0;
         sh_q     <= frame_i;
      end else if (active_q && fall_tk) begin
         sh_q <= sh_q << 1;
         if (last_bit) active_q <= 1'b0;
         else          bit_q    <= bit_q + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          rx_q <= '0;
      else if (active_q && rd_q && rise_tk) rx_q <= {rx_q[14:0], mdio_i};
   end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
   parameter int PRE_LEN   = 32,
   parameter bit CUSTOM_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_we,
   input  logic [15:0] cmd_wdata,
   output logic [15:0] cmd_rdata,
   input  logic        data_we,
   input  logic [15:0] data_wdata,
   output logic [15:0] data_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   import mdio_pkg::*;

   localparam int FL = PRE_LEN + 32;

   if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
      $error("PRE_LEN out of range");
   end

   logic [15:0]       cmd_q, data_q, rd_data;
   logic [HALF_W-1:0] half;
   logic              accept, start, done, rise_tk, fall_tk;
   logic [FL-1:0]     frame;

   assign accept = cmd_we && !cmd_q[0];
   assign start  = accept && cmd_wdata[0];

   if (CUSTOM_EN) begin : g_linear
      assign half = cmd_q[5] ? linear_half(cmd_q[5:2]) : band_half(cmd_q[5:2]);
   end else begin : g_band_only
      assign half = band_half(cmd_q[5:2]);
   end

   assign frame = {{PRE_LEN{1'b1}}, 2'b01,
                   (cmd_wdata[1] ? 2'b01 : 2'b10),
                   cmd_wdata[15:11], cmd_wdata[10:6], 2'b10, data_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmd_q <= '0;
      else if (accept) cmd_q <= cmd_wdata;
      else if (done)   cmd_q[0] <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     data_q <= '0;
      else if (done && !cmd_q[1])     data_q <= rd_data;
      else if (data_we && !cmd_q[0])  data_q <= data_wdata;
   end

   mdio_clk_div #(.HALF_W(HALF_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (cmd_q[0]),
      .half    (half),
      .mdc     (mdc),
      .rise_tk (rise_tk),
      .fall_tk (fall_tk)
   );

   mdio_frame_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .is_read (!cmd_wdata[1]),
      .frame_i (frame),
      .rise_tk (rise_tk),
      .fall_tk (fall_tk),
      .mdio_i  (mdio_i),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .done    (done),
      .rd_data (rd_data)
   );

   assign cmd_rdata  = cmd_q;
   assign data_rdata = data_q;

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_we,
   input logic [15:0] cmd_wdata,
   input logic [15:0] cmd_rdata,
   input logic [15:0] data_rdata,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe
);

   AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_rdata[0] |-> !mdc); // R6

   AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rdata[0] && cmd_we) |=> (cmd_rdata[15:1] == $past(cmd_rdata[15:1]))); // R3

   AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rdata[0] && $past(cmd_rdata[0])) |-> $stable(data_rdata)); // R3

   AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc)); // R10

   AST_START_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_rdata[0]) |-> $past(cmd_we && cmd_wdata[0])); // R2

   AST_OE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> cmd_rdata[0]); // R11

endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_we     (cmd_we),
   .cmd_wdata  (cmd_wdata),
   .cmd_rdata  (cmd_rdata),
   .data_rdata (data_rdata),
   .mdc        (mdc),
   .mdio_o     (mdio_o),
   .mdio_oe    (mdio_oe)
);

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [15:0] cmd_wdata = '0;
   logic [15:0] cmd_rdata;
   logic        data_we = 1'b0;
   logic [15:0] data_wdata = '0;
   logic [15:0] data_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   mdio_mgmt_master uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .cmd_rdata(cmd_rdata), .data_we(data_we), .data_wdata(data_wdata),
      .data_rdata(data_rdata), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // code, write, phy, reg, data/response, expected period
   typedef logic [38:0] vec_t;
   localparam vec_t VEC [16] = '{
      {4'h0, 1'b1, 5'd1,  5'd2,  16'hA5C3, 8'd42},
      {4'h1, 1'b0, 5'd3,  5'd4,  16'h5A3C, 8'd62},
      {4'h2, 1'b1, 5'd31, 5'd0,  16'hFFFF, 8'd16},
      {4'h3, 1'b0, 5'd0,  5'd31, 16'h0001, 8'd26},
      {4'h4, 1'b1, 5'd16, 5'd15, 16'h8000, 8'd102},
      {4'h5, 1'b0, 5'd7,  5'd9,  16'hC001, 8'd124},
      {4'h6, 1'b1, 5'd2,  5'd3,  16'h1234, 8'd42},
      {4'h7, 1'b0, 5'd4,  5'd5,  16'hBEEF, 8'd42},
      {4'h8, 1'b1, 5'd5,  5'd6,  16'h0F0F, 8'd4},
      {4'h9, 1'b0, 5'd6,  5'd7,  16'hF0F0, 8'd6},
      {4'hA, 1'b1, 5'd8,  5'd8,  16'h3C3C, 8'd8},
      {4'hB, 1'b0, 5'd9,  5'd1,  16'hAAAA, 8'd10},
      {4'hC, 1'b1, 5'd10, 5'd2,  16'h5555, 8'd12},
      {4'hD, 1'b0, 5'd11, 5'd3,  16'h7E81, 8'd14},
      {4'hE, 1'b1, 5'd12, 5'd4,  16'h0000, 8'd16},
      {4'hF, 1'b0, 5'd13, 5'd5,  16'hDEAD, 8'd18}
   };

   // bench-side PHY and line monitor
   logic [63:0] cap, oem;
   logic [15:0] resp = '0;
   int rc, fc, bdur, cyc, t0, per, hi, mdc_idle_hi;
   logic pb = 1'b0, pm = 1'b0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (cmd_rdata[0] && !pb) begin
         rc = 0; fc = 0; bdur = 0; cap = '0; oem = '0;
      end
      if (cmd_rdata[0]) bdur = bdur + 1;
      if (!cmd_rdata[0] && mdc) mdc_idle_hi = mdc_idle_hi + 1;
      if (mdc && !pm) begin
         if (rc < 64) begin
            cap[63-rc] = mdio_o;
            oem[63-rc] = mdio_oe;
         end
         if (rc == 0) t0 = cyc;
         if (rc == 1) per = cyc - t0;
         rc = rc + 1;
      end
      if (!mdc && pm) begin
         if (fc == 0) hi = cyc - t0;
         fc = fc + 1;
      end
      mdio_i = (rc >= 48 && rc < 64) ? resp[63-rc] : 1'b0;
      pb = cmd_rdata[0];
      pm = mdc;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_cmd(input logic [15:0] v);
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
      @(negedge clk); cmd_we = 1'b0;
   endtask

   task automatic wr_data(input logic [15:0] v);
      @(negedge clk); data_we = 1'b1; data_wdata = v;
      @(negedge clk); data_we = 1'b0;
   endtask

   task automatic run_op(input logic [3:0] code, input bit wr, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] dat,
                         input int div, input bit poke);
      logic [15:0] cmd;
      logic [63:0] exp;
      cmd = {phy, rg, code, wr, 1'b1};
      if (wr) wr_data(dat);
      else    resp = dat;
      wr_cmd(cmd);
      if (poke) begin
         repeat (20) @(negedge clk);
         wr_cmd(16'hFFFE ^ cmd);     // R3: ignored mid-frame
         wr_data(~dat);              // R3: ignored mid-frame
      end
      for (int i = 0; i < 20000 && cmd_rdata[0]; i++) @(negedge clk);
      exp = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, dat};
      if (wr) begin
         chk(cap == exp, "R7 R8 write frame", cap, exp);
         chk(oem == '1, "R8 write drive", oem, '1);
      end else begin
         chk(cap[63:18] == exp[63:18], "R7 read header", cap[63:18], exp[63:18]);
         chk(oem == {{46{1'b1}}, 18'd0}, "R9 read release", oem, {{46{1'b1}}, 18'd0});
      end
      chk(per == div, code[3] ? "R4 period" : "R5 period", per, div);
      chk(hi == div / 2, "R6 high time", hi, div / 2);
      chk(bdur == 64 * div, "R11 busy length", bdur, 64 * div);
      chk(data_rdata == dat, wr ? "R3 data kept" : "R9 R11 read data", data_rdata, dat);
      chk(cmd_rdata == {cmd[15:1], 1'b0}, "R2 R3 cmd after op", cmd_rdata, {cmd[15:1], 1'b0});
   endtask

   initial begin
      cyc = 0; mdc_idle_hi = 0; rc = 0; fc = 0; bdur = 0; per = 0; hi = 0; t0 = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cmd_rdata == 16'd0, "R1 cmd reset", cmd_rdata, 0);
      chk(data_rdata == 16'd0, "R1 data reset", data_rdata, 0);
      chk(mdc == 1'b0, "R1 mdc reset", mdc, 0);
      chk(mdio_oe == 1'b0, "R1 oe reset", mdio_oe, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int k = 0; k < 16; k++) begin
         vec_t v;
         v = VEC[k];
         run_op(v[38:35], v[34], v[33:29], v[28:24], v[23:8], int'(v[7:0]), 1'b0);
      end

      // R3 writes in the middle of a frame, write and read
      run_op(4'h8, 1'b1, 5'd21, 5'd10, 16'h6B29, 4, 1'b1);
      run_op(4'h9, 1'b0, 5'd26, 5'd17, 16'h93D4, 6, 1'b1);

      // R2 R6 command without busy is stored, no frame starts
      wr_cmd(16'hABCA);
      repeat (30) @(negedge clk);
      chk(cmd_rdata == 16'hABCA, "R2 store without start", cmd_rdata, 16'hABCA);
      chk(mdc_idle_hi == 0, "R6 mdc low while idle", mdc_idle_hi, 0);
      chk(mdio_oe == 1'b0, "R2 no drive without start", mdio_oe, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule